// File: doc/BRIEF.md
# Clock Nth-Chance Page Victim Selector

This block holds the replacement state for a pool of physical page frames and chooses which frame to evict when a page fault needs room. Each frame carries a recently-used flag, a modified flag and a small sweep counter. A reference port marks a frame as used, and a store reference also marks it modified. A write-back acknowledge port clears the modified flag once the frame's contents have reached backing storage.

When a fault request arrives, a circular pointer (the hand) visits one frame per clock. A used frame loses its used flag and its counter, and the hand moves on. An unused frame gains a count. It is evicted only once its count reaches its chance limit, which is larger for modified frames than for clean ones. A modified frame whose count first reaches the write-back point is announced on a write-back request pulse, so that its contents can be saved before it is evicted. The chosen frame is reported with a one-cycle valid pulse and a flag saying whether it still holds unsaved data. Its state is then wiped, and the hand rests on the following frame, ready for the next fault.

Top module: `nchance_victim_picker`

## Requirements
- R1: After reset every frame is unused, clean and has a zero count, the hand points at frame 0, and `busy`, `victim_valid` and `wb_req_valid` are 0.
- R2: A cycle with `ref_valid` high sets the used flag of frame `ref_frame`; when `ref_write` is also 1 the frame's modified flag is set too.
- R3: When the hand visits a frame whose used flag is 1, that flag and the frame's sweep count are cleared, and the hand moves to the next frame in the following cycle.
- R4: A clean frame visited with its used flag at 0 is chosen on that visit (chance limit 1), so a fault on a freshly reset pool picks the frame under the hand after one visit.
- R5: A modified frame visited with its used flag at 0 has its count incremented. When the count becomes 1, `wb_req_valid` pulses for one cycle with the frame number on `wb_req_frame`, and the hand moves on. When the count reaches 2, the frame is chosen with `victim_wb_needed` = 1.
- R6: `wb_ack_valid` clears the modified flag of frame `wb_ack_frame`; a frame acknowledged after its write-back request is then evicted as clean on its next unused visit.
- R7: A choice is reported for exactly one cycle: `victim_valid` = 1 with `victim_frame` and `victim_wb_needed`. In that same cycle `busy` is already 0.
- R8: After a choice the hand rests on the frame after the victim, wrapping from frame 31 to frame 0, and the next search starts there.
- R9: The chosen frame's used flag, modified flag and count are reset to 0.
- R10: A reference to the frame under the hand, in the cycle of its visit, wins. The frame is not chosen, its used flag ends at 1 and its count at 0, and the hand moves on.
- R11: A search always ends. With every frame used and clean it takes 33 visits; with all used and one modified frame under the hand, it takes 34 visits and picks the frame after that one.
- R12: `fault_req` is ignored while `busy` is 1: no second search starts after the current victim is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_valid | input | 1 | A frame was referenced this cycle |
| ref_write | input | 1 | The reference was a store |
| ref_frame | input | 5 | Referenced frame number |
| wb_ack_valid | input | 1 | Write-back of a frame has completed |
| wb_ack_frame | input | 5 | Frame whose write-back completed |
| fault_req | input | 1 | Start a victim search (taken when idle) |
| busy | output | 1 | A search is in progress |
| victim_valid | output | 1 | One-cycle pulse: a victim has been chosen |
| victim_frame | output | 5 | Number of the chosen frame |
| victim_wb_needed | output | 1 | Chosen frame still holds unsaved data |
| wb_req_valid | output | 1 | One-cycle pulse: a modified frame should be written back |
| wb_req_frame | output | 5 | Frame to be written back |

## Verification
The hardest states to reach are a modified frame whose count already stands at 1 when the hand returns to it, and a reference that lands on the very cycle the hand visits a frame. The bench reaches the first by marking every frame used with one store among them, so that a whole lap clears the flags and the second pass raises the write-back request. A further fault, after every other frame has been marked used again, then brings the hand back to evict it. The second is reached by timing a reference to the hand's frame in the first visit cycle after the fault is taken. A behavioural model of the frame pool is compared with the outputs every clock.

// File: rtl/nchance_pkg.sv
package nchance_pkg;

   typedef enum logic {
      HAND_IDLE  = 1'b0,
      HAND_SWEEP = 1'b1
   } hand_state_e;

endpackage

// File: rtl/nchance_frame_slot.sv
module nchance_frame_slot #(
   parameter int CLEAN_CHANCES = 1,
   parameter int DIRTY_CHANCES = 2,
   parameter int WB_FLAG_AT    = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_hit,
   input  logic ref_wr,
   input  logic ack_hit,
   input  logic visit,
   output logic pick,
   output logic wb_flag,
   output logic dirty_o
);

   localparam int CNT_W = $clog2(DIRTY_CHANCES + 1);

   logic             use_q;
   logic             dirty_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   cnt_inc;
   logic [CNT_W:0]   limit;
   logic             sweep_hit;
   logic             spent;

   always_comb begin
      sweep_hit = visit && !ref_hit;
      spent     = sweep_hit && !use_q;
      cnt_inc   = {1'b0, cnt_q} + (CNT_W+1)'(1);
      limit     = dirty_q ? (CNT_W+1)'(DIRTY_CHANCES) : (CNT_W+1)'(CLEAN_CHANCES);
      pick      = spent && (cnt_inc >= limit);
      wb_flag   = spent && dirty_q && !pick && (cnt_inc == (CNT_W+1)'(WB_FLAG_AT));
   end

   assign dirty_o = dirty_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         use_q   <= 1'b0;
         dirty_q <= 1'b0;
         cnt_q   <= '0;
      end else begin
         if (ref_hit) begin
            use_q <= 1'b1;
         end else if (visit) begin
            use_q <= 1'b0;
         end

         if (visit && (ref_hit || use_q || pick)) begin
            cnt_q <= '0;
         end else if (spent) begin
            cnt_q <= cnt_inc[CNT_W-1:0];
         end

         if (ref_hit && ref_wr) begin
            dirty_q <= 1'b1;
         end else if (pick || ack_hit) begin
            dirty_q <= 1'b0;
         end
      end
   end

   // R2: a reference always leaves the used flag set
   p_ref_sets_use_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ref_hit |=> use_q);

   // R2: a store reference leaves the modified flag set
   p_store_sets_dirty_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_hit && ref_wr) |=> dirty_q);

   // R3: a used frame under the hand is cleared and keeps a zero count
   p_used_visit_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (visit && use_q && !ref_hit) |=> (!use_q && cnt_q == '0));

   // R6: acknowledge clears the modified flag unless a store lands together
   p_ack_clears_dirty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit && !(ref_hit && ref_wr)) |=> !dirty_q);

   // R9: the chosen frame comes back fully wiped
   p_victim_wiped_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pick |=> (!use_q && !dirty_q && cnt_q == '0));

   // R10: a colliding reference leaves the frame used with zero count
   p_ref_wins_visit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (visit && ref_hit) |=> (use_q && cnt_q == '0));

endmodule

// File: rtl/nchance_hand_ctrl.sv
module nchance_hand_ctrl
   import nchance_pkg::*;
#(
   parameter int NUM_FRAMES = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          fault_req,
   input  logic                          any_pick,
   input  logic                          any_wb_flag,
   input  logic                          picked_dirty,
   output logic [$clog2(NUM_FRAMES)-1:0] hand_o,
   output logic                          sweeping,
   output logic                          victim_valid,
   output logic [$clog2(NUM_FRAMES)-1:0] victim_frame,
   output logic                          victim_wb_needed,
   output logic                          wb_req_valid,
   output logic [$clog2(NUM_FRAMES)-1:0] wb_req_frame
);

   localparam int FRAME_W = $clog2(NUM_FRAMES);
   localparam logic [FRAME_W-1:0] LAST_FRAME = FRAME_W'(NUM_FRAMES - 1);

   hand_state_e      state_q;
   logic [FRAME_W-1:0] hand_q;
   logic [FRAME_W-1:0] hand_step;

   generate
      if (NUM_FRAMES == (1 << FRAME_W)) begin : g_pow2_wrap
         assign hand_step = hand_q + 1'b1;
      end else begin : g_cmp_wrap
         assign hand_step = (hand_q == LAST_FRAME) ? '0 : hand_q + 1'b1;
      end
   endgenerate

   assign sweeping = (state_q == HAND_SWEEP);
   assign hand_o   = hand_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q          <= HAND_IDLE;
         hand_q           <= '0;
         victim_valid     <= 1'b0;
         victim_frame     <= '0;
         victim_wb_needed <= 1'b0;
         wb_req_valid     <= 1'b0;
         wb_req_frame     <= '0;
      end else begin
         victim_valid <= 1'b0;
         wb_req_valid <= 1'b0;
         case (state_q)
            HAND_IDLE: begin
               if (fault_req) begin
                  state_q <= HAND_SWEEP;
               end
            end
            HAND_SWEEP: begin
               hand_q <= hand_step;
               if (any_wb_flag) begin
                  wb_req_valid <= 1'b1;
                  wb_req_frame <= hand_q;
               end
               if (any_pick) begin
                  state_q          <= HAND_IDLE;
                  victim_valid     <= 1'b1;
                  victim_frame     <= hand_q;
                  victim_wb_needed <= picked_dirty;
               end
            end
            default: state_q <= HAND_IDLE;
         endcase
      end
   end

   // R7: a victim pulse lasts one cycle
   p_victim_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      victim_valid |=> !victim_valid);

   // R7: the search is already over when the victim is shown
   p_idle_with_victim_r7: assert property (@(posedge clk) disable iff (!rst_n)
      victim_valid |-> !sweeping);

   // R8: the hand rests one past the reported victim
   p_hand_after_victim_r8: assert property (@(posedge clk) disable iff (!rst_n)
      victim_valid |-> (hand_q == ((victim_frame == LAST_FRAME) ? '0 : victim_frame + 1'b1)));

   // R12: a running search continues until a frame is chosen
   p_search_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (sweeping && !any_pick) |=> sweeping);

   // R3: the hand advances one frame every sweep cycle
   p_hand_steps_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sweeping |=> (hand_q == $past(hand_step)));

endmodule

// File: rtl/nchance_victim_picker.sv
module nchance_victim_picker #(
   parameter int NUM_FRAMES    = 32,
   parameter int CLEAN_CHANCES = 1,
   parameter int DIRTY_CHANCES = 2,
   parameter int WB_FLAG_AT    = 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          ref_valid,
   input  logic                          ref_write,
   input  logic [$clog2(NUM_FRAMES)-1:0] ref_frame,
   input  logic                          wb_ack_valid,
   input  logic [$clog2(NUM_FRAMES)-1:0] wb_ack_frame,
   input  logic                          fault_req,
   output logic                          busy,
   output logic                          victim_valid,
   output logic [$clog2(NUM_FRAMES)-1:0] victim_frame,
   output logic                          victim_wb_needed,
   output logic                          wb_req_valid,
   output logic [$clog2(NUM_FRAMES)-1:0] wb_req_frame
);

   localparam int FRAME_W = $clog2(NUM_FRAMES);

   generate
      if (NUM_FRAMES < 2) begin : g_bad_frames
         $error("nchance_victim_picker: NUM_FRAMES must be at least 2");
      end
      if (CLEAN_CHANCES < 1) begin : g_bad_clean
         $error("nchance_victim_picker: CLEAN_CHANCES must be at least 1");
      end
      if (DIRTY_CHANCES < CLEAN_CHANCES) begin : g_bad_dirty
         $error("nchance_victim_picker: DIRTY_CHANCES must not be below CLEAN_CHANCES");
      end
      if (WB_FLAG_AT < 1 || WB_FLAG_AT >= DIRTY_CHANCES) begin : g_bad_wb
         $error("nchance_victim_picker: WB_FLAG_AT must lie in 1..DIRTY_CHANCES-1");
      end
   endgenerate

   logic [FRAME_W-1:0]    hand;
   logic                  sweeping;
   logic [NUM_FRAMES-1:0] ref_hit_vec;
   logic [NUM_FRAMES-1:0] ack_hit_vec;
   logic [NUM_FRAMES-1:0] visit_vec;
   logic [NUM_FRAMES-1:0] pick_vec;
   logic [NUM_FRAMES-1:0] wb_flag_vec;
   logic [NUM_FRAMES-1:0] dirty_vec;
   logic                  any_pick;
   logic                  any_wb_flag;
   logic                  picked_dirty;

   generate
      for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_slot
         assign ref_hit_vec[i] = ref_valid && (ref_frame == FRAME_W'(i));
         assign ack_hit_vec[i] = wb_ack_valid && (wb_ack_frame == FRAME_W'(i));
         assign visit_vec[i]   = sweeping && (hand == FRAME_W'(i));

         nchance_frame_slot #(
            .CLEAN_CHANCES (CLEAN_CHANCES),
            .DIRTY_CHANCES (DIRTY_CHANCES),
            .WB_FLAG_AT    (WB_FLAG_AT)
         ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .ref_hit (ref_hit_vec[i]),
            .ref_wr  (ref_write),
            .ack_hit (ack_hit_vec[i]),
            .visit   (visit_vec[i]),
            .pick    (pick_vec[i]),
            .wb_flag (wb_flag_vec[i]),
            .dirty_o (dirty_vec[i])
         );
      end
   endgenerate

   assign any_pick     = |pick_vec;
   assign any_wb_flag  = |wb_flag_vec;
   assign picked_dirty = dirty_vec[hand];
   assign busy         = sweeping;

   nchance_hand_ctrl #(
      .NUM_FRAMES (NUM_FRAMES)
   ) u_hand (
      .clk              (clk),
      .rst_n            (rst_n),
      .fault_req        (fault_req),
      .any_pick         (any_pick),
      .any_wb_flag      (any_wb_flag),
      .picked_dirty     (picked_dirty),
      .hand_o           (hand),
      .sweeping         (sweeping),
      .victim_valid     (victim_valid),
      .victim_frame     (victim_frame),
      .victim_wb_needed (victim_wb_needed),
      .wb_req_valid     (wb_req_valid),
      .wb_req_frame     (wb_req_frame)
   );

   // R7: at most one frame is chosen per cycle
   p_single_pick_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pick_vec));

   // R5: the write-back request names a frame that still holds unsaved data
   p_wb_req_dirty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      any_wb_flag |=> (wb_req_valid && dirty_vec[wb_req_frame]));

   // R1: nothing is reported while no search has run
   p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!sweeping) |=> (!victim_valid && !wb_req_valid));

endmodule

// File: tb/nchance_victim_picker_bench.sv
module nchance_victim_picker_bench;

   localparam int NF = 32;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_valid = 1'b0;
   logic       ref_write = 1'b0;
   logic [4:0] ref_frame = '0;
   logic       wb_ack_valid = 1'b0;
   logic [4:0] wb_ack_frame = '0;
   logic       fault_req = 1'b0;
   logic       busy;
   logic       victim_valid;
   logic [4:0] victim_frame;
   logic       victim_wb_needed;
   logic       wb_req_valid;
   logic [4:0] wb_req_frame;

   always #10 clk = ~clk;

   nchance_victim_picker u_nchance_victim_picker (
      .clk              (clk),
      .rst_n            (rst_n),
      .ref_valid        (ref_valid),
      .ref_write        (ref_write),
      .ref_frame        (ref_frame),
      .wb_ack_valid     (wb_ack_valid),
      .wb_ack_frame     (wb_ack_frame),
      .fault_req        (fault_req),
      .busy             (busy),
      .victim_valid     (victim_valid),
      .victim_frame     (victim_frame),
      .victim_wb_needed (victim_wb_needed),
      .wb_req_valid     (wb_req_valid),
      .wb_req_frame     (wb_req_frame)
   );

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;
   int wb_seen = 0;
   int last_wbf = -1;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // behavioural model of the frame pool
   bit m_use   [NF];
   bit m_dirty [NF];
   int m_cnt   [NF];
   int m_hand;
   bit m_busy;
   bit e_vv, e_vw, e_wbv;
   int e_vf, e_wbf;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int f = 0; f < NF; f++) begin
            m_use[f] = 0; m_dirty[f] = 0; m_cnt[f] = 0;
         end
         m_hand = 0; m_busy = 0;
         e_vv = 0; e_vw = 0; e_wbv = 0; e_vf = 0; e_wbf = 0;
      end else begin
         e_vv  = 0;
         e_wbv = 0;
         if (m_busy) begin
            int  f;
            bit  hit;
            bit  chosen;
            int  c;
            int  lim;
            f = m_hand;
            hit = ref_valid && (int'(ref_frame) == f);
            chosen = 0;
            if (hit || m_use[f]) begin
               m_cnt[f] = 0;
               m_use[f] = 0;
            end else begin
               c = m_cnt[f] + 1;
               lim = m_dirty[f] ? 2 : 1;
               if (c >= lim) chosen = 1;
               else begin
                  m_cnt[f] = c;
                  if (m_dirty[f] && c == 1) begin
                     e_wbv = 1;
                     e_wbf = f;
                  end
               end
            end
            if (chosen) begin
               e_vv = 1; e_vf = f; e_vw = m_dirty[f];
               m_use[f] = 0; m_dirty[f] = 0; m_cnt[f] = 0;
               m_busy = 0;
            end
            m_hand = (f + 1) % NF;
         end else if (fault_req) begin
            m_busy = 1;
         end
         if (wb_ack_valid) m_dirty[wb_ack_frame] = 0;
         if (ref_valid) begin
            m_use[ref_frame] = 1;
            if (ref_write) m_dirty[ref_frame] = 1;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(busy == m_busy, "R12", "busy", busy, m_busy);
         chk(victim_valid == e_vv, "R7", "victim_valid", victim_valid, e_vv);
         if (e_vv) begin
            chk(int'(victim_frame) == e_vf, "R7", "victim_frame", victim_frame, e_vf);
            chk(victim_wb_needed == e_vw, "R7", "victim_wb_needed", victim_wb_needed, e_vw);
         end
         chk(wb_req_valid == e_wbv, "R5", "wb_req_valid", wb_req_valid, e_wbv);
         if (e_wbv) chk(int'(wb_req_frame) == e_wbf, "R5", "wb_req_frame", wb_req_frame, e_wbf);
         if (wb_req_valid) begin
            wb_seen++;
            last_wbf = int'(wb_req_frame);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic ref_one(input int f, input bit wr);
      @(negedge clk);
      ref_valid = 1'b1;
      ref_frame = 5'(f);
      ref_write = wr;
      @(negedge clk);
      ref_valid = 1'b0;
      ref_write = 1'b0;
   endtask

   task automatic ref_all(input int skip, input int wr_frame);
      for (int f = 0; f < NF; f++) begin
         if (f != skip) ref_one(f, f == wr_frame);
      end
   endtask

   task automatic ack_one(input int f);
      @(negedge clk);
      wb_ack_valid = 1'b1;
      wb_ack_frame = 5'(f);
      @(negedge clk);
      wb_ack_valid = 1'b0;
   endtask

   task automatic do_fault(input int exp_f, input bit exp_w, input string tag,
                           input int collide, input bit poke, output int visits);
      int n;
      n = 0;
      @(negedge clk);
      fault_req = 1'b1;
      @(negedge clk);
      fault_req = 1'b0;
      if (collide >= 0) begin
         ref_valid = 1'b1;
         ref_frame = 5'(collide);
         ref_write = 1'b0;
      end
      while (!victim_valid && n < 500) begin
         @(negedge clk);
         ref_valid = 1'b0;
         fault_req = (poke && n == 2);
         n++;
      end
      ref_valid = 1'b0;
      fault_req = 1'b0;
      visits = n;
      chk(int'(victim_frame) == exp_f, tag, "victim frame", victim_frame, exp_f);
      chk(victim_wb_needed == exp_w, tag, "write-back flag", victim_wb_needed, exp_w);
   endtask

   initial begin
      int v;
      int w0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
      chk(victim_valid == 1'b0, "R1", "victim_valid after reset", victim_valid, 0);
      chk(wb_req_valid == 1'b0, "R1", "wb_req_valid after reset", wb_req_valid, 0);

      // R4: fresh pool picks the frame under the hand at once
      do_fault(0, 0, "R4", -1, 0, v);
      chk(v == 1, "R4", "visits on fresh pool", v, 1);
      @(negedge clk);
      chk(victim_valid == 1'b0, "R7", "victim pulse length", victim_valid, 0);
      chk(busy == 1'b0, "R7", "busy after victim", busy, 0);

      // R8: next search starts after the previous victim
      do_fault(1, 0, "R8", -1, 0, v);

      // R2 R3: used frames are skipped and cleared
      ref_one(2, 0);
      ref_one(3, 0);
      do_fault(4, 0, "R3", -1, 0, v);
      chk(v == 3, "R3", "visits past two used frames", v, 3);

      // R11 R12 R2: all used, one store; fault poked mid-search
      ref_all(-1, 5);
      w0 = wb_seen;
      do_fault(6, 0, "R11", -1, 1, v);
      chk(v == 34, "R11", "visits with all frames used", v, 34);
      chk(wb_seen - w0 == 1, "R2", "write-back requests", wb_seen - w0, 1);
      chk(last_wbf == 5, "R5", "write-back frame", last_wbf, 5);
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, "R12", "no search from ignored fault", busy, 0);

      // R5: dirty frame evicted on its second unused visit
      ref_all(5, -1);
      do_fault(5, 1, "R5", -1, 0, v);
      chk(v == 31, "R5", "visits to dirty victim", v, 31);

      // R9: evicted frame comes back clean with zero count
      ref_all(5, -1);
      do_fault(5, 0, "R9", -1, 0, v);
      chk(v == 32, "R9", "visits to wiped frame", v, 32);

      // R6: acknowledged frame is evicted as clean
      ref_all(-1, 6);
      w0 = wb_seen;
      do_fault(7, 0, "R6", -1, 0, v);
      chk(last_wbf == 6, "R6", "write-back frame", last_wbf, 6);
      ack_one(6);
      ref_all(6, -1);
      do_fault(6, 0, "R6", -1, 0, v);
      chk(v == 31, "R6", "visits to acknowledged frame", v, 31);

      // R10: reference in the visit cycle wins
      do_fault(8, 0, "R10", 7, 0, v);
      chk(v == 2, "R10", "visits with colliding reference", v, 2);

      // R8: wrap from the last frame to frame 0
      for (int f = 9; f <= 30; f++) ref_one(f, 0);
      do_fault(31, 0, "R8", -1, 0, v);
      chk(v == 23, "R8", "visits up to last frame", v, 23);
      do_fault(0, 0, "R8", -1, 0, v);
      chk(v == 1, "R8", "visits after wrap", v, 1);

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule